// File: doc/BRIEF.md
# Processor stack and control-flow sequencer

This block performs the stack-based flow operations of an 8-bit processor: single-byte push and pull, saving and restoring the status byte, subroutine call and return, return from interrupt and the software break. The surrounding core pulses `start` with a 3-bit operation code while presenting the current program counter, stack pointer and status byte. The sequencer then walks through the required memory accesses on a byte-wide port, one access per clock. Stack accesses go to page one (`$01xx`). The block returns the new PC, S and P together with a one-cycle `done` pulse.

Memory reads are combinational as seen by the block: `mem_rdata` must hold the byte at `mem_addr` during the same cycle in which `mem_re` is high, and the block samples it at the closing clock edge. Writes take effect at the clock edge that ends a cycle with `mem_we` high. Instruction decode, operand fetch and interrupt arbitration belong to the surrounding core.

Top module: `stack_flow_seq`

## Requirements
- R1: A push byte operation (op code 0) writes `push_data` to address `$0100 + S` and returns S decremented by one, with wrap from $00 to $FF. Every stack write lands in page `$01`.
- R2: A pull byte operation (op code 1) first increments S, wrapping from $FF to $00, then reads `$0100 + S`. The byte read appears on `pull_data`.
- R3: Every 16-bit push writes the high byte and then the low byte. Every 16-bit pull reads the low byte and then the high byte. Each byte is a separate stack access, so S may wrap between the two bytes.
- R4: A status push (op code 2) writes P with bit 4 forced to 1 and returns P unchanged.
- R5: A status pull (op code 3) returns the byte read with bit 5 forced to 1 and bit 4 forced to 0.
- R6: A call (op code 4) pushes `pc_in - 1` as a 16-bit value and returns `target_in` as the new PC.
- R7: A return (op code 5) pulls a 16-bit value and returns that value plus one as the new PC.
- R8: A return from interrupt (op code 6) performs the status pull of R5 first. It then pulls the 16-bit PC and applies no increment.
- R9: A break (op code 7) pushes `pc_in + 1` and then P with bit 4 set. It then reads the new PC low byte from `$FFFE` and high byte from `$FFFF`. The returned P has bit 2 set and bit 3 cleared.
- R10: Each access takes exactly one clock with at most one of `mem_we`/`mem_re` high. `done` is high for the single cycle after the last access, when the new PC/S/P are already on the outputs. A `start` that arrives while `busy` is high is ignored.
- R11: After reset, S reads $FF, P reads $34, PC reads $0000, the block is idle and it makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code (0..7, see requirements) |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| target_in | input | 16 | Call destination |
| push_data | input | 8 | Byte for the push byte operation |
| mem_addr | output | 16 | Memory address of the current access |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| p_out | output | 8 | Updated status byte |
| pull_data | output | 8 | Byte obtained by the last pull byte operation |

## Verification
The bench aims at stack-pointer wrap at both ends. It pushes at S=$00 and pulls at S=$FF, and it runs a call whose two return-address bytes straddle the wrap. A design that wraps through page `$00` or `$02`, or that puts S back in the wrong order, would touch the wrong address. The bench also targets the status shaping: bit 4 written as 1 and read back as 0, and bit 5 forced on. It checks the off-by-one rules of call, return and return from interrupt, where a design that adds or drops the increment returns to the neighbouring instruction. Finally, it sends a stream of starts during a busy call; a sequencer that accepted them would corrupt the access sequence on the port.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_BYTE = 3'd0,
    OP_PULL_BYTE = 3'd1,
    OP_PUSH_STAT = 3'd2,
    OP_PULL_STAT = 3'd3,
    OP_CALL      = 3'd4,
    OP_RETURN    = 3'd5,
    OP_RETI      = 3'd6,
    OP_BREAK     = 3'd7
  } flow_op_e;

  // kind of memory access a step performs
  typedef enum logic [1:0] {
    ACC_PUSH   = 2'd0,
    ACC_PULL   = 2'd1,
    ACC_VEC_LO = 2'd2,
    ACC_VEC_HI = 2'd3
  } acc_e;

  // source of write data
  typedef enum logic [1:0] {
    WS_DATA   = 2'd0,
    WS_RET_HI = 2'd1,
    WS_RET_LO = 2'd2,
    WS_STAT   = 2'd3
  } wsel_e;

  // destination of read data
  typedef enum logic [1:0] {
    RD_BYTE = 2'd0,
    RD_STAT = 2'd1,
    RD_LO   = 2'd2,
    RD_HI   = 2'd3
  } rsel_e;

  typedef struct packed {
    acc_e  acc;
    wsel_e wsel;
    rsel_e rsel;
    logic  last;
  } step_t;

  // status bit positions the sequencer manipulates
  localparam int unsigned IRQ_BIT   = 2;
  localparam int unsigned DEC_BIT   = 3;
  localparam int unsigned BRK_BIT   = 4;
  localparam int unsigned SPARE_BIT = 5;

  function automatic logic [7:0] stat_to_stack(input logic [7:0] p);
    logic [7:0] v;
    v = p;
    v[BRK_BIT] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] stat_from_stack(input logic [7:0] b);
    logic [7:0] v;
    v = b;
    v[SPARE_BIT] = 1'b1;
    v[BRK_BIT]   = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] stat_after_break(input logic [7:0] p);
    logic [7:0] v;
    v = p;
    v[IRQ_BIT] = 1'b1;
    v[DEC_BIT] = 1'b0;
    return v;
  endfunction

  function automatic step_t mk_step(input acc_e a, input wsel_e w, input rsel_e r,
                                    input logic l);
    step_t s;
    s.acc  = a;
    s.wsel = w;
    s.rsel = r;
    s.last = l;
    return s;
  endfunction

endpackage

// File: rtl/ssq_step_rom.sv
module ssq_step_rom
  import stack_seq_pkg::*;
#(
  parameter int unsigned STEP_W = 3
) (
  input  flow_op_e            op,
  input  logic [STEP_W-1:0]   step,
  output step_t               st
);

  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);

  always_comb begin
    st = mk_step(ACC_PUSH, WS_DATA, RD_BYTE, 1'b1);
    unique case (op)
      OP_PUSH_BYTE: st = mk_step(ACC_PUSH, WS_DATA, RD_BYTE, 1'b1);
      OP_PULL_BYTE: st = mk_step(ACC_PULL, WS_DATA, RD_BYTE, 1'b1);
      OP_PUSH_STAT: st = mk_step(ACC_PUSH, WS_STAT, RD_BYTE, 1'b1);
      OP_PULL_STAT: st = mk_step(ACC_PULL, WS_DATA, RD_STAT, 1'b1);
      OP_CALL: begin
        if (step == S0) st = mk_step(ACC_PUSH, WS_RET_HI, RD_BYTE, 1'b0);
        else            st = mk_step(ACC_PUSH, WS_RET_LO, RD_BYTE, 1'b1);
      end
      OP_RETURN: begin
        if (step == S0) st = mk_step(ACC_PULL, WS_DATA, RD_LO, 1'b0);
        else            st = mk_step(ACC_PULL, WS_DATA, RD_HI, 1'b1);
      end
      OP_RETI: begin
        if (step == S0)      st = mk_step(ACC_PULL, WS_DATA, RD_STAT, 1'b0);
        else if (step == S1) st = mk_step(ACC_PULL, WS_DATA, RD_LO,   1'b0);
        else                 st = mk_step(ACC_PULL, WS_DATA, RD_HI,   1'b1);
      end
      OP_BREAK: begin
        if (step == S0)      st = mk_step(ACC_PUSH,   WS_RET_HI, RD_BYTE, 1'b0);
        else if (step == S1) st = mk_step(ACC_PUSH,   WS_RET_LO, RD_BYTE, 1'b0);
        else if (step == S2) st = mk_step(ACC_PUSH,   WS_STAT,   RD_BYTE, 1'b0);
        else if (step == S3) st = mk_step(ACC_VEC_LO, WS_DATA,   RD_LO,   1'b0);
        else                 st = mk_step(ACC_VEC_HI, WS_DATA,   RD_HI,   1'b1);
      end
      default: st = mk_step(ACC_PUSH, WS_DATA, RD_BYTE, 1'b1);
    endcase
  end

endmodule

// File: rtl/ssq_addr_gen.sv
module ssq_addr_gen
  import stack_seq_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned STACK_PAGE = 'h01,
  parameter int unsigned VECTOR     = 'hFFFE
) (
  input  acc_e           acc,
  input  logic [DW-1:0]  sp,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  sp_nxt
);

  localparam int unsigned PW = AW - DW;
  localparam logic [PW-1:0] PAGE   = PW'(STACK_PAGE);
  localparam logic [AW-1:0] VEC_LO = AW'(VECTOR);
  localparam logic [AW-1:0] VEC_HI = AW'(VECTOR + 1);
  localparam logic [DW-1:0] ONE_D  = DW'(1);

  logic [DW-1:0] sp_inc;
  logic [DW-1:0] sp_dec;

  assign sp_inc = sp + ONE_D;
  assign sp_dec = sp - ONE_D;

  always_comb begin
    unique case (acc)
      ACC_PUSH: begin
        addr   = {PAGE, sp};
        sp_nxt = sp_dec;
      end
      ACC_PULL: begin
        addr   = {PAGE, sp_inc};
        sp_nxt = sp_inc;
      end
      ACC_VEC_LO: begin
        addr   = VEC_LO;
        sp_nxt = sp;
      end
      default: begin
        addr   = VEC_HI;
        sp_nxt = sp;
      end
    endcase
  end

endmodule

// File: rtl/stack_flow_seq.sv
module stack_flow_seq
  import stack_seq_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned STACK_PAGE = 'h01,
  parameter int unsigned VECTOR     = 'hFFFE,
  parameter int unsigned SP_RESET   = 'hFF,
  parameter int unsigned P_RESET    = 'h34,
  parameter int unsigned STEP_W     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] p_in,
  input  logic [AW-1:0] target_in,
  input  logic [DW-1:0] push_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] p_out,
  output logic [DW-1:0] pull_data
);

  localparam logic [AW-1:0]     ONE_A    = AW'(1);
  localparam logic [STEP_W-1:0] ONE_S    = STEP_W'(1);
  localparam logic [DW-1:0]     SP_INIT  = DW'(SP_RESET);
  localparam logic [DW-1:0]     P_INIT   = DW'(P_RESET);

  flow_op_e            op_q;
  logic [STEP_W-1:0]   step_q;
  logic                busy_q;
  logic                done_q;
  logic [DW-1:0]       sp_w;
  logic [DW-1:0]       p_w;
  logic [AW-1:0]       ret_q;
  logic [AW-1:0]       pc_q;
  logic [AW-1:0]       tgt_q;
  logic [DW-1:0]       lo_q;
  logic [DW-1:0]       dat_q;

  step_t               st;
  logic [AW-1:0]       addr_c;
  logic [DW-1:0]       sp_nxt;
  logic                is_push;
  logic [DW-1:0]       wdata_c;
  logic [AW-1:0]       word_rd;
  logic [AW-1:0]       pc_fin;
  logic [DW-1:0]       p_fin;

  ssq_step_rom #(.STEP_W(STEP_W)) u_rom (
    .op   (op_q),
    .step (step_q),
    .st   (st)
  );

  ssq_addr_gen #(
    .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE), .VECTOR(VECTOR)
  ) u_addr (
    .acc    (st.acc),
    .sp     (sp_w),
    .addr   (addr_c),
    .sp_nxt (sp_nxt)
  );

  assign is_push = (st.acc == ACC_PUSH);

  always_comb begin
    unique case (st.wsel)
      WS_DATA:   wdata_c = dat_q;
      WS_RET_HI: wdata_c = ret_q[AW-1:AW-DW];
      WS_RET_LO: wdata_c = ret_q[DW-1:0];
      default:   wdata_c = stat_to_stack(p_w);
    endcase
  end

  // a 16-bit value read in two halves, high half arriving on the last step
  assign word_rd = {mem_rdata, lo_q};

  always_comb begin
    unique case (op_q)
      OP_CALL:   pc_fin = tgt_q;
      OP_RETURN: pc_fin = word_rd + ONE_A;
      OP_RETI,
      OP_BREAK:  pc_fin = word_rd;
      default:   pc_fin = pc_q;
    endcase
  end

  always_comb begin
    if (st.rsel == RD_STAT && st.acc == ACC_PULL) p_fin = stat_from_stack(mem_rdata);
    else if (op_q == OP_BREAK)                   p_fin = stat_after_break(p_w);
    else                                         p_fin = p_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_PUSH_BYTE;
      step_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sp_w      <= SP_INIT;
      p_w       <= P_INIT;
      ret_q     <= '0;
      pc_q      <= '0;
      tgt_q     <= '0;
      lo_q      <= '0;
      dat_q     <= '0;
      pc_out    <= '0;
      sp_out    <= SP_INIT;
      p_out     <= P_INIT;
      pull_data <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          op_q   <= flow_op_e'(op);
          step_q <= '0;
          busy_q <= 1'b1;
          sp_w   <= sp_in;
          p_w    <= p_in;
          pc_q   <= pc_in;
          tgt_q  <= target_in;
          dat_q  <= push_data;
          ret_q  <= (flow_op_e'(op) == OP_CALL) ? (pc_in - ONE_A) : (pc_in + ONE_A);
        end
      end else begin
        sp_w   <= sp_nxt;
        step_q <= step_q + ONE_S;
        if (!is_push) begin
          unique case (st.rsel)
            RD_STAT: p_w       <= stat_from_stack(mem_rdata);
            RD_LO:   lo_q      <= mem_rdata;
            RD_BYTE: pull_data <= mem_rdata;
            default: ;
          endcase
        end
        if (st.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          sp_out <= sp_nxt;
          p_out  <= p_fin;
          pc_out <= pc_fin;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_addr  = addr_c;
  assign mem_we    = busy_q & is_push;
  assign mem_re    = busy_q & ~is_push;
  assign mem_wdata = wdata_c;

endmodule

// File: rtl/stack_flow_seq_chk.sv
module stack_flow_seq_chk #(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned STACK_PAGE = 'h01,
  parameter int unsigned VECTOR     = 'hFFFE
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          done
);

  localparam logic [AW-DW-1:0] PAGE = (AW-DW)'(STACK_PAGE);
  localparam logic [AW-1:0]    VEC  = AW'(VECTOR);
  localparam logic [DW-1:0]    ONE  = DW'(1);

  logic on_page;
  assign on_page = (mem_addr[AW-1:DW] == PAGE);

  AST_WRITE_IN_STACK_PAGE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> on_page); // R1

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - ONE)); // R3

  AST_PULL_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re) && on_page && ($past(mem_addr[AW-1:DW]) == PAGE))
      |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + ONE)); // R2

  AST_OFF_PAGE_READ_IS_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (mem_re && !on_page) |-> (mem_addr >= VEC)); // R9

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re)); // R11

  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(mem_we || mem_re))); // R10

endmodule

bind stack_flow_seq stack_flow_seq_chk #(
  .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE), .VECTOR(VECTOR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .busy     (busy),
  .done     (done)
);

// File: tb/stack_flow_seq_test.sv
`timescale 1ns/1ps
module stack_flow_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  p_in = '0;
  logic [15:0] target_in = '0;
  logic [7:0]  push_data = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy;
  logic        done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;
  logic [7:0]  p_out;
  logic [7:0]  pull_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  stack_flow_seq uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .pc_in(pc_in), .sp_in(sp_in),
    .p_in(p_in), .target_in(target_in), .push_data(push_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
    .sp_out(sp_out), .p_out(p_out), .pull_data(pull_data)
  );

  // environment memory
  logic [7:0] mem [int];

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  always @(posedge clk) if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  always @(negedge clk) mem_rdata = rd(mem_addr);

  // reference model state
  logic [15:0] ea[$];
  logic        ew[$];
  logic [7:0]  ed[$];
  logic [7:0]  m_s;
  logic [15:0] e_pc;
  logic [7:0]  e_p;
  logic [7:0]  e_data = 8'h00;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [7:0] b);
    ea.push_back({8'h01, m_s}); ew.push_back(1'b1); ed.push_back(b);
    m_s = m_s - 8'd1;
  endtask

  task automatic m_pull(output logic [7:0] b);
    m_s = m_s + 8'd1;
    ea.push_back({8'h01, m_s}); ew.push_back(1'b0); ed.push_back(8'h00);
    b = rd({8'h01, m_s});
  endtask

  task automatic m_vec(input logic [15:0] a, output logic [7:0] b);
    ea.push_back(a); ew.push_back(1'b0); ed.push_back(8'h00);
    b = rd(a);
  endtask

  task automatic run_op(input string req, input logic [2:0] opc, input logic [15:0] pc,
                        input logic [7:0] sp, input logic [7:0] p, input logic [7:0] dat,
                        input logic [15:0] tgt, input bit spam);
    logic [15:0] r;
    logic [7:0]  lo, hi, b;
    ea.delete(); ew.delete(); ed.delete();
    m_s = sp; e_pc = pc; e_p = p;
    case (opc)
      3'd0: m_push(dat);
      3'd1: begin m_pull(b); e_data = b; end
      3'd2: m_push(p | 8'h10);
      3'd3: begin m_pull(b); e_p = (b | 8'h20) & 8'hEF; end
      3'd4: begin r = pc - 16'd1; m_push(r[15:8]); m_push(r[7:0]); e_pc = tgt; end
      3'd5: begin m_pull(lo); m_pull(hi); e_pc = {hi, lo} + 16'd1; end
      3'd6: begin m_pull(b); e_p = (b | 8'h20) & 8'hEF; m_pull(lo); m_pull(hi); e_pc = {hi, lo}; end
      default: begin
        r = pc + 16'd1; m_push(r[15:8]); m_push(r[7:0]); m_push(p | 8'h10);
        e_p = (p | 8'h04) & 8'hF7;
        m_vec(16'hFFFE, lo); m_vec(16'hFFFF, hi); e_pc = {hi, lo};
      end
    endcase
    @(negedge clk);
    start = 1'b1; op = opc; pc_in = pc; sp_in = sp; p_in = p; push_data = dat; target_in = tgt;
    @(negedge clk);
    if (spam) begin start = 1'b1; op = 3'd0; push_data = 8'hEE; sp_in = 8'h10; end
    else start = 1'b0;
    foreach (ea[i]) begin
      if (i == ea.size() - 1) start = 1'b0;
      check(req, "busy", busy, 1'b1);
      check(req, "access kind", {mem_we, mem_re}, {ew[i], ~ew[i]});
      check(req, "address", mem_addr, ea[i]);
      if (ew[i]) check(req, "write data", mem_wdata, ed[i]);
      @(negedge clk);
    end
    check(req, "done", {done, busy}, 2'b10);
    check(req, "pc_out", pc_out, e_pc);
    check(req, "sp_out", sp_out, m_s);
    check(req, "p_out", p_out, e_p);
    check(req, "pull_data", pull_data, e_data);
    @(negedge clk);
    check(req, "done pulse ends, idle", {done, busy, mem_we, mem_re}, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    mem[16'hFFFE] = 8'h00;
    mem[16'hFFFF] = 8'hC0;
    mem[16'h0180] = 8'hD3;
    mem[16'h0141] = 8'hFF;
    mem[16'h0142] = 8'hCD;
    mem[16'h0143] = 8'hAB;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11", "sp_out", sp_out, 8'hFF);
    check("R11", "p_out", p_out, 8'h34);
    check("R11", "pc_out", pc_out, 16'h0000);
    check("R11", "idle", {busy, done, mem_we, mem_re}, 4'b0000);

    run_op("R1",  3'd0, 16'h0300, 8'hFF, 8'h34, 8'hA5, 16'h0, 0);
    run_op("R2",  3'd1, 16'h0300, 8'hFE, 8'h34, 8'h00, 16'h0, 0);
    run_op("R1",  3'd0, 16'h0300, 8'h00, 8'h34, 8'h5C, 16'h0, 0);
    run_op("R2",  3'd1, 16'h0300, 8'hFF, 8'h34, 8'h00, 16'h0, 0);
    run_op("R4",  3'd2, 16'h0300, 8'hFF, 8'h00, 8'h00, 16'h0, 0);
    run_op("R5",  3'd3, 16'h0300, 8'hFE, 8'h00, 8'h00, 16'h0, 0);
    run_op("R5",  3'd3, 16'h0300, 8'h7F, 8'h00, 8'h00, 16'h0, 0);
    run_op("R6_R3", 3'd4, 16'h1234, 8'h00, 8'h21, 8'h00, 16'h8000, 0);
    run_op("R7_R3", 3'd5, 16'h8000, 8'hFE, 8'h21, 8'h00, 16'h0, 0);
    run_op("R8",  3'd6, 16'h0500, 8'h40, 8'h00, 8'h00, 16'h0, 0);
    run_op("R9",  3'd7, 16'h2000, 8'hFF, 8'h0B, 8'h00, 16'h0, 0);
    run_op("R10", 3'd4, 16'h4000, 8'h80, 8'h30, 8'h00, 16'h9000, 1);
    run_op("R7",  3'd5, 16'h9000, 8'h7E, 8'h30, 8'h00, 16'h0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule